// File: doc/BRIEF.md
# Sprite Data Counter with Expansion-Clear Corruption

This block keeps the two 6-bit byte counters that walk one sprite through its 63-byte image: a running data counter that advances once per fetched sprite byte, and a base counter that marks where the current sprite line starts. At a fixed point late in each raster line the data counter is reloaded from the base. At a fixed point early in the line the base is advanced to the data counter whenever the vertical expansion flip-flop allows it. The block also owns the sprite's DMA-enable and display-enable flags, and it selects which byte a sprite fetch slot delivers.

The block models one timing hazard. If software clears the sprite's vertical expansion bit during the second half of the cycle just before the base update, the base does not take a clean copy of the data counter. It takes a bitwise blend of the two counters instead. On odd bit positions the old base and the data counter are ANDed. On even positions they are ORed. The end-of-sprite test (base equal to 63) runs on the value that results, so a corrupted base can end the sprite early or make it run past its normal end. Reaching the end only stops DMA. The display flag is left on until the later reload point, so the last line of the sprite is drawn completely.

The enclosing video controller supplies the raster cycle number, the half-cycle phase, writes to the expansion bit, the expansion flip-flop, the per-byte fetch strobe, a DMA start pulse from its Y comparison, and the two candidate fetch bytes. Each clock edge handles one half-cycle.

Top module: `spr_mcount`

## Requirements
- R1: While reset is held, and after it is released, `mc` and `mcbase` are 0 and `dma_on` and `disp_on` are 0.
- R2: A `dma_start` pulse while `dma_on` is 0 sets `dma_on` to 1 and clears `mcbase` to 0 at that edge. While `dma_on` is 1, `dma_start` has no effect on either.
- R3: An edge with `fetch_inc`=1 and `dma_on`=1 raises `mc` by one, wrapping from 63 to 0. With `dma_on`=0, `fetch_inc` leaves `mc` unchanged.
- R4: At the edge with `cyc`=58 and `ph`=0 (first phase), `mc` is loaded from `mcbase` and `disp_on` takes the value of `dma_on`. At no other edge does `disp_on` change.
- R5: At the edge with `cyc`=16 and `ph`=0, when `exp_ff`=1 and no clearing write is pending, `mcbase` is loaded from `mc`. When `exp_ff`=0, `mcbase` keeps its value. `mc` does not change at this edge.
- R6: A write (`yexp_we`=1, `yexp_wd`=0) at `cyc`=15 with `ph`=1 (second phase), while the stored expansion bit is 1, arms a pending clear. The next `cyc`=16/`ph`=0 edge with `exp_ff`=1 then loads `mcbase` with a blend of `mcbase` and `mc`. Bits 1, 3 and 5 take the AND of the two counters, and bits 0, 2 and 4 take the OR. The cycle-16 edge consumes the pending clear.
- R7: A clearing write at any other cycle or phase, or a write of 0 while the stored bit is already 0, arms nothing. The following update then copies `mc` normally.
- R8: At the `cyc`=16/`ph`=0 edge, `dma_on` drops to 0 if the value of `mcbase` after that edge is 63. `disp_on` keeps its value at that edge.
- R9: `fetch_data` equals `mem_data` while `dma_on`=1. With `dma_on`=0 it equals `bus_data` when `bus_valid`=1, and 8'hFF otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc | input | 6 | Raster cycle number of this half-cycle |
| ph | input | 1 | Phase: 0 first, 1 second |
| yexp_we | input | 1 | Write strobe for the expansion bit |
| yexp_wd | input | 1 | Value written to the expansion bit |
| exp_ff | input | 1 | Vertical expansion flip-flop |
| dma_start | input | 1 | Y-match request to begin sprite DMA |
| fetch_inc | input | 1 | One sprite data byte fetched |
| mem_data | input | 8 | Byte read from memory in a DMA slot |
| bus_data | input | 8 | Byte on the internal bus in an idle slot |
| bus_valid | input | 1 | Internal bus carried an access |
| mc | output | 6 | Data counter |
| mcbase | output | 6 | Base counter |
| dma_on | output | 1 | Sprite DMA enabled |
| disp_on | output | 1 | Sprite display enabled |
| fetch_data | output | 8 | Byte delivered by the sprite fetch slot |

## Verification
A wrong base value shows on `mcbase` one edge after the cycle-16 update. If that value is wrongly 63, or wrongly not 63, the error also shows on `dma_on` at that same edge. One reload later it reaches `mc` and `disp_on`, so the following line fetches from the wrong byte. A mis-armed pending clear is invisible until the next update edge. The sweep therefore pairs each arming pattern with an immediate update and compares the counters there. A wrong `disp_on` stays hidden until cycle 58, which is why the bench checks it both at the cycle-16 edge and after the next reload.

// File: rtl/spr_mcount_pkg.sv
package spr_mcount_pkg;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } half_e;

  localparam int MIX_MAX_W = 16;

  // Alternating mask: ones on odd bit positions
  function automatic logic [MIX_MAX_W-1:0] odd_mask();
    logic [MIX_MAX_W-1:0] m;
    for (int i = 0; i < MIX_MAX_W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  // Base corruption: AND on odd positions, OR on even positions
  function automatic logic [MIX_MAX_W-1:0] crunch_mix(
    input logic [MIX_MAX_W-1:0] base,
    input logic [MIX_MAX_W-1:0] cnt
  );
    logic [MIX_MAX_W-1:0] m;
    m = odd_mask();
    return (m & (base & cnt)) | (~m & (base | cnt));
  endfunction

endpackage

// File: rtl/spr_yexp_track.sv
module spr_yexp_track (
  input  logic clk,
  input  logic rst_n,
  input  logic yexp_we,
  input  logic yexp_wd,
  input  logic at_crit,
  input  logic at_upd,
  output logic yexp_q,
  output logic crunch_q
);

  logic clear_hit;

  assign clear_hit = yexp_we && !yexp_wd && yexp_q && at_crit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      yexp_q   <= 1'b0;
      crunch_q <= 1'b0;
    end else begin
      if (yexp_we) yexp_q <= yexp_wd;
      if (clear_hit)   crunch_q <= 1'b1;
      else if (at_upd) crunch_q <= 1'b0;
    end
  end

endmodule

// File: rtl/spr_cnt_core.sv
module spr_cnt_core
  import spr_mcount_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_upd,
  input  logic          at_disp,
  input  logic          exp_ff,
  input  logic          crunch,
  input  logic          dma_start,
  input  logic          fetch_inc,
  output logic [CW-1:0] mc,
  output logic [CW-1:0] mcbase,
  output logic          dma_on,
  output logic          disp_on,
  output logic [CW-1:0] base_next
);

  localparam logic [CW-1:0] END_VAL = {CW{1'b1}};
  localparam int PAD = MIX_MAX_W - CW;

  logic [MIX_MAX_W-1:0] mix_w;
  logic [CW-1:0]        upd_val;
  logic                 start_go;
  logic                 end_hit;

  assign mix_w = crunch_mix({{PAD{1'b0}}, mcbase}, {{PAD{1'b0}}, mc});

  generate
    if (CW < MIX_MAX_W) begin : g_narrow
      assign upd_val = crunch ? mix_w[CW-1:0] : mc;
    end else begin : g_full
      assign upd_val = crunch ? mix_w : mc;
    end
  endgenerate

  assign base_next = (at_upd && exp_ff) ? upd_val : mcbase;
  assign start_go  = dma_start && !dma_on;
  assign end_hit   = at_upd && (base_next == END_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc      <= '0;
      mcbase  <= '0;
      dma_on  <= 1'b0;
      disp_on <= 1'b0;
    end else begin
      if (at_disp)                mc <= mcbase;
      else if (fetch_inc && dma_on) mc <= mc + 1'b1;

      if (at_upd && exp_ff) mcbase <= upd_val;
      else if (start_go)    mcbase <= '0;

      if (start_go)     dma_on <= 1'b1;
      else if (end_hit) dma_on <= 1'b0;

      if (at_disp) disp_on <= dma_on;
    end
  end

endmodule

// File: rtl/spr_fetch_mux.sv
module spr_fetch_mux #(
  parameter int DW = 8
) (
  input  logic          dma_on,
  input  logic [DW-1:0] mem_data,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_valid,
  output logic [DW-1:0] fetch_data
);

  always_comb begin
    if (dma_on)         fetch_data = mem_data;
    else if (bus_valid) fetch_data = bus_data;
    else                fetch_data = {DW{1'b1}};
  end

endmodule

// File: rtl/spr_mcount.sv
module spr_mcount
  import spr_mcount_pkg::*;
#(
  parameter int CW         = 6,
  parameter int CYC_W      = 6,
  parameter int DW         = 8,
  parameter int CRIT_CYC   = 15,
  parameter int UPD_CYC    = 16,
  parameter int RELOAD_CYC = 58
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cyc,
  input  logic             ph,
  input  logic             yexp_we,
  input  logic             yexp_wd,
  input  logic             exp_ff,
  input  logic             dma_start,
  input  logic             fetch_inc,
  input  logic [DW-1:0]    mem_data,
  input  logic [DW-1:0]    bus_data,
  input  logic             bus_valid,
  output logic [CW-1:0]    mc,
  output logic [CW-1:0]    mcbase,
  output logic             dma_on,
  output logic             disp_on,
  output logic [DW-1:0]    fetch_data
);

  localparam logic [CYC_W-1:0] C_CRIT = CYC_W'(CRIT_CYC);
  localparam logic [CYC_W-1:0] C_UPD  = CYC_W'(UPD_CYC);
  localparam logic [CYC_W-1:0] C_REL  = CYC_W'(RELOAD_CYC);

  // Named events for the checker
  logic ev_crit, ev_upd, ev_disp;
  logic yexp_q, crunch_q;
  logic [CW-1:0] base_next;

  assign ev_crit = (cyc == C_CRIT) && (ph == PH_SECOND);
  assign ev_upd  = (cyc == C_UPD)  && (ph == PH_FIRST);
  assign ev_disp = (cyc == C_REL)  && (ph == PH_FIRST);

  spr_yexp_track u_yexp (
    .clk      (clk),
    .rst_n    (rst_n),
    .yexp_we  (yexp_we),
    .yexp_wd  (yexp_wd),
    .at_crit  (ev_crit),
    .at_upd   (ev_upd),
    .yexp_q   (yexp_q),
    .crunch_q (crunch_q)
  );

  spr_cnt_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .at_upd    (ev_upd),
    .at_disp   (ev_disp),
    .exp_ff    (exp_ff),
    .crunch    (crunch_q),
    .dma_start (dma_start),
    .fetch_inc (fetch_inc),
    .mc        (mc),
    .mcbase    (mcbase),
    .dma_on    (dma_on),
    .disp_on   (disp_on),
    .base_next (base_next)
  );

  spr_fetch_mux #(.DW(DW)) u_mux (
    .dma_on     (dma_on),
    .mem_data   (mem_data),
    .bus_data   (bus_data),
    .bus_valid  (bus_valid),
    .fetch_data (fetch_data)
  );

endmodule

// File: rtl/spr_mcount_chk.sv
module spr_mcount_chk
  import spr_mcount_pkg::*;
#(
  parameter int CW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_upd,
  input logic          ev_disp,
  input logic          exp_ff,
  input logic          crunch_q,
  input logic          dma_start,
  input logic          fetch_inc,
  input logic          bus_valid,
  input logic [DW-1:0] mem_data,
  input logic [CW-1:0] mc,
  input logic [CW-1:0] mcbase,
  input logic          dma_on,
  input logic          disp_on,
  input logic [DW-1:0] fetch_data
);

  localparam int PAD = MIX_MAX_W - CW;
  localparam logic [CW-1:0] END_VAL = {CW{1'b1}};

  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start && !dma_on && !ev_upd |=> dma_on && mcbase == '0);

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_inc && dma_on && !ev_disp |=> mc == CW'($past(mc) + 1'b1));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_disp |=> mc == $past(mcbase) && disp_on == $past(dma_on));

  // R4
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_disp |=> $stable(disp_on));

  // R5
  plain_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd && exp_ff && !crunch_q |=> mcbase == $past(mc));

  // R6
  blend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd && exp_ff && crunch_q |=>
      mcbase == CW'(crunch_mix({{PAD{1'b0}}, $past(mcbase)}, {{PAD{1'b0}}, $past(mc)})));

  // R8
  end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd && dma_on && !dma_start |=> dma_on == (mcbase != END_VAL));

  // R9
  idle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on && !bus_valid |-> fetch_data == {DW{1'b1}});

  // R9
  dma_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on |-> fetch_data == mem_data);

endmodule

bind spr_mcount spr_mcount_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_upd     (ev_upd),
  .ev_disp    (ev_disp),
  .exp_ff     (exp_ff),
  .crunch_q   (crunch_q),
  .dma_start  (dma_start),
  .fetch_inc  (fetch_inc),
  .bus_valid  (bus_valid),
  .mem_data   (mem_data),
  .mc         (mc),
  .mcbase     (mcbase),
  .dma_on     (dma_on),
  .disp_on    (disp_on),
  .fetch_data (fetch_data)
);

// File: tb/sim_spr_mcount.sv
module sim_spr_mcount;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cyc = 6'd30;
  logic       ph = 1'b0;
  logic       yexp_we = 1'b0, yexp_wd = 1'b0, exp_ff = 1'b0;
  logic       dma_start = 1'b0, fetch_inc = 1'b0;
  logic [7:0] mem_data = 8'h00, bus_data = 8'h00;
  logic       bus_valid = 1'b0;
  logic [5:0] mc, mcbase;
  logic       dma_on, disp_on;
  logic [7:0] fetch_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spr_mcount u0 (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .ph(ph),
    .yexp_we(yexp_we), .yexp_wd(yexp_wd), .exp_ff(exp_ff),
    .dma_start(dma_start), .fetch_inc(fetch_inc),
    .mem_data(mem_data), .bus_data(bus_data), .bus_valid(bus_valid),
    .mc(mc), .mcbase(mcbase), .dma_on(dma_on), .disp_on(disp_on),
    .fetch_data(fetch_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Reference blend: per bit, odd positions AND, even positions OR
  function automatic int mix_ref(input int b, input int m);
    int r = 0;
    for (int i = 0; i < 6; i++) begin
      int bb = (b >> i) & 1;
      int mm = (m >> i) & 1;
      int v = (i % 2 == 1) ? (bb * mm) : ((bb + mm) > 0 ? 1 : 0);
      r = r + (v << i);
    end
    return r;
  endfunction

  task automatic at(input int c, input bit p);
    cyc = 6'(c); ph = p; tick(); cyc = 6'd30; ph = 1'b0;
  endtask

  task automatic incs(input int n);
    fetch_inc = 1'b1;
    repeat (n) tick();
    fetch_inc = 1'b0;
  endtask

  task automatic wr_yexp(input int c, input bit p, input bit v);
    yexp_we = 1'b1; yexp_wd = v; at(c, p); yexp_we = 1'b0;
  endtask

  task automatic update(input bit ef);
    exp_ff = ef; at(16, 0); exp_ff = 1'b0;
  endtask

  task automatic set_base(input int b);
    if (!dma_on) begin dma_start = 1'b1; tick(); dma_start = 1'b0; end
    at(58, 0);
    incs((b - int'(mcbase)) & 63);
    update(1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state, during and after reset
    chk("R1 mc", int'(mc), 0);
    chk("R1 dma", int'(dma_on), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 mcbase", int'(mcbase), 0);
    chk("R1 disp", int'(disp_on), 0);

    // R9 idle fetch
    bus_valid = 1'b0; #1;
    chk("R9 idle ff", int'(fetch_data), 255);
    bus_valid = 1'b1; bus_data = 8'h5A; #1;
    chk("R9 bus", int'(fetch_data), 8'h5A);

    // R3 increments ignored with DMA off
    incs(3);
    chk("R3 off", int'(mc), 0);

    // R2 start
    dma_start = 1'b1; tick(); dma_start = 1'b0;
    chk("R2 dma", int'(dma_on), 1);
    chk("R2 base", int'(mcbase), 0);
    mem_data = 8'hC3; #1;
    chk("R9 mem", int'(fetch_data), 8'hC3);

    // R3 increments and R5 plain copy
    incs(5);
    chk("R3 inc", int'(mc), 5);
    update(1'b0);
    chk("R5 ef0 keeps", int'(mcbase), 0);
    update(1'b1);
    chk("R5 copy", int'(mcbase), 5);
    chk("R5 mc hold", int'(mc), 5);

    // R2 start ignored when on
    dma_start = 1'b1; tick(); dma_start = 1'b0;
    chk("R2 ignored", int'(mcbase), 5);

    // R4 reload
    incs(2);
    at(58, 0);
    chk("R4 mc", int'(mc), 5);
    chk("R4 disp", int'(disp_on), 1);

    // R7 non-arming clears
    wr_yexp(30, 0, 1'b1);
    wr_yexp(15, 0, 1'b0);
    incs(9);
    update(1'b1);
    chk("R7 wrong phase", int'(mcbase), 14);
    wr_yexp(30, 0, 1'b1);
    wr_yexp(14, 1, 1'b0);
    incs(7);
    update(1'b1);
    chk("R7 wrong cycle", int'(mcbase), 21);
    wr_yexp(15, 1, 1'b0);
    incs(11);
    update(1'b1);
    chk("R7 already zero", int'(mcbase), 32);

    // R3 wrap
    set_base(62);
    incs(2);
    chk("R3 wrap", int'(mc), 0);

    // R8 plain copy to 63 ends DMA, display held
    set_base(62);
    incs(1);
    update(1'b1);
    chk("R8 dma off", int'(dma_on), 0);
    chk("R8 disp held", int'(disp_on), 1);
    at(58, 0);
    chk("R8 disp later", int'(disp_on), 0);
    chk("R4 mc 63", int'(mc), 63);
    bus_valid = 1'b0; #1;
    chk("R9 idle after end", int'(fetch_data), 255);

    // R6 / R8 sweep of base and data counter pairs under the clear
    for (int b = 0; b < 63; b += 7) begin
      for (int m = 0; m < 64; m++) begin
        int e;
        set_base(b);
        incs((m - b) & 63);
        wr_yexp(30, 0, 1'b1);
        wr_yexp(15, 1, 1'b0);
        update(1'b1);
        e = mix_ref(b, m);
        chk("R6 blend", int'(mcbase), e);
        chk("R8 end test", int'(dma_on), (e == 63) ? 0 : 1);
        chk("R5 mc unchanged", int'(mc), m);
      end
    end

    // R6 pending clear consumed by the update edge
    set_base(3);
    incs(4);
    wr_yexp(30, 0, 1'b1);
    wr_yexp(15, 1, 1'b0);
    update(1'b1);
    chk("R6 blend once", int'(mcbase), mix_ref(3, 7));
    at(58, 0);
    incs(2);
    update(1'b1);
    chk("R6 consumed", int'(mcbase), (mix_ref(3, 7) + 2) & 63);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule